// File: doc/BRIEF.md
# DMA-to-MAC FIFO Glue

This block sits between a byte-oriented DMA controller and the transmit and receive FIFOs of an Ethernet MAC. All of them run on one system clock. It forms a 24-bit memory address from three bytes. The low byte comes straight from the controller. The middle byte is captured off the controller's data bus while its address strobe is high. The top byte is a page register that only the host writes.

One DMA channel fills the transmit FIFO and is requested whenever that FIFO has room. A second channel empties the receive FIFO and is requested whenever that FIFO holds data. Each FIFO access is stretched by a programmable number of wait cycles so that it fits a three-cycle controller transfer.

The controller pulses its end-of-process line low at every terminal count, including at the end of each buffer of a gathered packet. The block passes that pulse on as end-of-frame only after the host has flagged the current buffer as the last one of the packet. A second host flag marks a packet of odd length moved in words. With that flag set, the final word is reported as carrying just one valid byte.

Top module: `dma_fifo_glue`

## Requirements
- R1: A synchronous reset clears the middle byte, the page byte, both packet flags, both requests and the wait counter. After reset, `dreq_tx`, `dreq_rx`, `fifo_rdy`, `mac_eof` and `addr_valid` are 0, `hi_byte_valid` is 1, and `mem_addr` is 0 while no acknowledge is active.
- R2: On every clock edge where `ctl_adstb` is 1, the middle address byte takes `ctl_data`. On all other edges it keeps its value.
- R3: The page byte changes only on a clock edge where `host_page_we` is 1, and then it takes `host_page_data`.
- R4: While `dack_tx_n` or `dack_rx_n` is low, `addr_valid` is 1 and `mem_addr` equals {page, middle byte, `ctl_lo_addr`}, with the page in bits [23:16] and the low byte in bits [7:0]. Otherwise both outputs are 0.
- R5: `dreq_tx` is `tx_space` delayed by one clock, and `dreq_rx` is `rx_avail` delayed by one clock. Both are active high.
- R6: `fifo_rdy` is 0 for the first WAIT_CYCLES cycles of an acknowledge (an acknowledge is either acknowledge line held low). It is 1 from the next cycle on, as long as the acknowledge stays active. It is 0 whenever no acknowledge is active.
- R7: `mac_eof` is 1 in exactly those cycles where `eop_n` is low, an acknowledge is active and the last-buffer flag is set. An end-of-process pulse while the flag is clear is ignored.
- R8: A host flag write (`host_flag_we`=1) loads the last-buffer flag from `host_flag_last` and the odd-length flag from `host_flag_odd`. Without a write, the clock edge that closes a cycle with `mac_eof`=1 clears both flags. A write in that same cycle takes precedence.
- R9: `hi_byte_valid` is 0 only in a cycle where `mac_eof` is 1 and the odd-length flag is set. In every other cycle it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock shared with the controller and the MAC |
| rst | input | 1 | Synchronous reset, active high |
| ctl_lo_addr | input | 8 | Low address byte driven by the DMA controller |
| ctl_data | input | 8 | Controller data bus, which carries the middle address byte during the strobe |
| ctl_adstb | input | 1 | Address strobe from the controller, active high |
| dack_tx_n | input | 1 | Acknowledge for the transmit-fill channel, active low |
| dack_rx_n | input | 1 | Acknowledge for the receive-drain channel, active low |
| eop_n | input | 1 | Terminal-count pulse from the controller, active low |
| host_page_we | input | 1 | Host I/O write strobe for the page register |
| host_page_data | input | 8 | Value written to the page register |
| host_flag_we | input | 1 | Host I/O write strobe for the packet flags |
| host_flag_last | input | 1 | Last-buffer flag value to write |
| host_flag_odd | input | 1 | Odd-length flag value to write |
| tx_space | input | 1 | Transmit FIFO can accept data |
| rx_avail | input | 1 | Receive FIFO holds data |
| dreq_tx | output | 1 | DMA request for the transmit-fill channel |
| dreq_rx | output | 1 | DMA request for the receive-drain channel |
| fifo_rdy | output | 1 | FIFO access may complete in this cycle |
| mem_addr | output | 24 | Composed memory address |
| addr_valid | output | 1 | An acknowledge is active and `mem_addr` is meaningful |
| mac_eof | output | 1 | End of frame for the MAC on the current transfer |
| hi_byte_valid | output | 1 | Upper byte of the current word is valid |

## Verification
The bench keeps the 8-bit address fields but builds the block with WAIT_CYCLES set to 2. The wait counter therefore has to count through a middle value and hold there, which a single wait state would not exercise. Acknowledges are held for random runs of cycles, so bursts shorter than the wait window are covered as well as longer ones. The bench also switches directly between the two channels. End-of-process pulses arrive both with and without the last-buffer flag set, and the directed cases include a host flag write that lands in the same cycle as an end-of-frame.

// File: rtl/dma_glue_pkg.sv
package dma_glue_pkg;
    // Per-packet host flags, cleared together when end-of-frame is issued.
    typedef struct packed {
        logic last;
        logic odd;
    } pkt_flags_t;
endpackage

// File: rtl/dma_addr_build.sv
module dma_addr_build #(
    parameter int LO_W   = 8,
    parameter int MID_W  = 8,
    parameter int PAGE_W = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         strobe,
    input  logic [MID_W-1:0]             bus_data,
    input  logic                         page_we,
    input  logic [PAGE_W-1:0]            page_data,
    input  logic [LO_W-1:0]              lo_byte,
    input  logic                         ack,
    output logic [LO_W+MID_W+PAGE_W-1:0] addr
);
    localparam int ADDR_W = LO_W + MID_W + PAGE_W;

    typedef struct packed {
        logic [MID_W-1:0]  mid;
        logic [PAGE_W-1:0] page;
    } addr_state_t;

    addr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (strobe)  st_d.mid  = bus_data;
        if (page_we) st_d.page = page_data;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb begin
        addr = '0;
        if (ack) addr = {st_q.page, st_q.mid, lo_byte};
    end

    AST_MID_HOLD: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(st_q.mid)); // R2
    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !page_we |=> $stable(st_q.page)); // R3
    AST_ADDR_IDLE: assert property (@(posedge clk) disable iff (rst)
        !ack |-> (addr == {ADDR_W{1'b0}})); // R4
endmodule

// File: rtl/dma_req_ctl.sv
module dma_req_ctl #(
    parameter int WAIT_CYCLES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_space,
    input  logic rx_avail,
    input  logic ack,
    output logic dreq_tx,
    output logic dreq_rx,
    output logic fifo_rdy
);
    localparam int CNT_W = (WAIT_CYCLES < 1) ? 1 : $clog2(WAIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(WAIT_CYCLES);

    typedef struct packed {
        logic             dtx;
        logic             drx;
        logic [CNT_W-1:0] cnt;
    } req_state_t;

    req_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.dtx = tx_space;
        st_d.drx = rx_avail;
        if (!ack)                st_d.cnt = '0;
        else if (st_q.cnt != CNT_TOP) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dreq_tx  = st_q.dtx;
    assign dreq_rx  = st_q.drx;
    assign fifo_rdy = ack && (st_q.cnt >= CNT_TOP);

    AST_DREQ_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        tx_space |=> dreq_tx); // R5
    AST_FIRST_WAIT: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> !fifo_rdy); // R6
    AST_RDY_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
        fifo_rdy |-> ack); // R6
endmodule

// File: rtl/dma_eof_qual.sv
module dma_eof_qual
    import dma_glue_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic eop_n,
    input  logic ack,
    input  logic flag_we,
    input  logic wr_last,
    input  logic wr_odd,
    output logic mac_eof,
    output logic hi_byte_valid
);
    pkt_flags_t fl_d, fl_q;
    logic       eof_now;

    assign eof_now = ack && !eop_n && fl_q.last;

    always_comb begin
        fl_d = fl_q;
        if (flag_we) begin
            fl_d.last = wr_last;
            fl_d.odd  = wr_odd;
        end else if (eof_now) begin
            fl_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) fl_q <= '0;
        else     fl_q <= fl_d;
    end

    assign mac_eof       = eof_now;
    assign hi_byte_valid = !(eof_now && fl_q.odd);

    AST_EOF_ONCE: assert property (@(posedge clk) disable iff (rst)
        (mac_eof && !flag_we) |=> !mac_eof); // R8
    AST_ODD_ONCE: assert property (@(posedge clk) disable iff (rst)
        (!hi_byte_valid && !flag_we) |=> hi_byte_valid); // R9
    AST_EOF_NEEDS_EOP: assert property (@(posedge clk) disable iff (rst)
        mac_eof |-> (!eop_n && ack)); // R7
endmodule

// File: rtl/dma_fifo_glue.sv
module dma_fifo_glue #(
    parameter int LO_W        = 8,
    parameter int MID_W       = 8,
    parameter int PAGE_W      = 8,
    parameter int WAIT_CYCLES = 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [LO_W-1:0]              ctl_lo_addr,
    input  logic [MID_W-1:0]             ctl_data,
    input  logic                         ctl_adstb,
    input  logic                         dack_tx_n,
    input  logic                         dack_rx_n,
    input  logic                         eop_n,
    input  logic                         host_page_we,
    input  logic [PAGE_W-1:0]            host_page_data,
    input  logic                         host_flag_we,
    input  logic                         host_flag_last,
    input  logic                         host_flag_odd,
    input  logic                         tx_space,
    input  logic                         rx_avail,
    output logic                         dreq_tx,
    output logic                         dreq_rx,
    output logic                         fifo_rdy,
    output logic [LO_W+MID_W+PAGE_W-1:0] mem_addr,
    output logic                         addr_valid,
    output logic                         mac_eof,
    output logic                         hi_byte_valid
);
    logic ack;

    assign ack        = !dack_tx_n || !dack_rx_n;
    assign addr_valid = ack;

    dma_addr_build #(
        .LO_W   (LO_W),
        .MID_W  (MID_W),
        .PAGE_W (PAGE_W)
    ) u_addr (
        .clk       (clk),
        .rst       (rst),
        .strobe    (ctl_adstb),
        .bus_data  (ctl_data),
        .page_we   (host_page_we),
        .page_data (host_page_data),
        .lo_byte   (ctl_lo_addr),
        .ack       (ack),
        .addr      (mem_addr)
    );

    dma_req_ctl #(
        .WAIT_CYCLES (WAIT_CYCLES)
    ) u_req (
        .clk      (clk),
        .rst      (rst),
        .tx_space (tx_space),
        .rx_avail (rx_avail),
        .ack      (ack),
        .dreq_tx  (dreq_tx),
        .dreq_rx  (dreq_rx),
        .fifo_rdy (fifo_rdy)
    );

    dma_eof_qual u_eof (
        .clk           (clk),
        .rst           (rst),
        .eop_n         (eop_n),
        .ack           (ack),
        .flag_we       (host_flag_we),
        .wr_last       (host_flag_last),
        .wr_odd        (host_flag_odd),
        .mac_eof       (mac_eof),
        .hi_byte_valid (hi_byte_valid)
    );
endmodule

// File: tb/dma_fifo_glue_tb.sv
`timescale 1ns/1ps
module dma_fifo_glue_tb;
    localparam int W = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  ctl_lo_addr = '0, ctl_data = '0, host_page_data = '0;
    logic        ctl_adstb = 0, dack_tx_n = 1, dack_rx_n = 1, eop_n = 1;
    logic        host_page_we = 0, host_flag_we = 0, host_flag_last = 0, host_flag_odd = 0;
    logic        tx_space = 0, rx_avail = 0;
    logic        dreq_tx, dreq_rx, fifo_rdy, addr_valid, mac_eof, hi_byte_valid;
    logic [23:0] mem_addr;

    int checks = 0;
    int fails  = 0;

    // bench model state
    logic [7:0] m_mid = 0, m_page = 0;
    logic       m_last = 0, m_odd = 0, m_dtx = 0, m_drx = 0;
    int         m_cnt = 0;

    always #2.5 clk = ~clk;

    dma_fifo_glue #(.WAIT_CYCLES(W)) u_dut (
        .clk(clk), .rst(rst), .ctl_lo_addr(ctl_lo_addr), .ctl_data(ctl_data),
        .ctl_adstb(ctl_adstb), .dack_tx_n(dack_tx_n), .dack_rx_n(dack_rx_n),
        .eop_n(eop_n), .host_page_we(host_page_we), .host_page_data(host_page_data),
        .host_flag_we(host_flag_we), .host_flag_last(host_flag_last),
        .host_flag_odd(host_flag_odd), .tx_space(tx_space), .rx_avail(rx_avail),
        .dreq_tx(dreq_tx), .dreq_rx(dreq_rx), .fifo_rdy(fifo_rdy),
        .mem_addr(mem_addr), .addr_valid(addr_valid), .mac_eof(mac_eof),
        .hi_byte_valid(hi_byte_valid)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic ack_f();
        return !dack_tx_n || !dack_rx_n;
    endfunction

    function automatic logic eof_f();
        return ack_f() && !eop_n && m_last;
    endfunction

    function automatic logic [23:0] addr_f();
        return ack_f() ? {m_page, m_mid, ctl_lo_addr} : 24'h0;
    endfunction

    // check outputs against the model, then advance one clock
    task automatic cycle();
        logic e;
        #1;
        e = eof_f();
        chk(mem_addr, addr_f(), "R4 mem_addr");
        chk(addr_valid, ack_f(), "R4 addr_valid");
        chk(dreq_tx, m_dtx, "R5 dreq_tx");
        chk(dreq_rx, m_drx, "R5 dreq_rx");
        chk(fifo_rdy, ack_f() && (m_cnt >= W), "R6 fifo_rdy");
        chk(mac_eof, e, "R7 mac_eof");
        chk(hi_byte_valid, !(e && m_odd), "R9 hi_byte_valid");
        @(posedge clk);
        if (rst) begin
            m_mid = 0; m_page = 0; m_last = 0; m_odd = 0; m_dtx = 0; m_drx = 0; m_cnt = 0;
        end else begin
            if (ctl_adstb) m_mid = ctl_data;
            if (host_page_we) m_page = host_page_data;
            if (host_flag_we) begin m_last = host_flag_last; m_odd = host_flag_odd; end
            else if (e) begin m_last = 0; m_odd = 0; end
            m_dtx = tx_space;
            m_drx = rx_avail;
            m_cnt = !ack_f() ? 0 : ((m_cnt == W) ? W : m_cnt + 1);
        end
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        ctl_adstb = 0; host_page_we = 0; host_flag_we = 0; eop_n = 1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int ack_sel;
        void'($urandom(32'd20240611));
        @(negedge clk);
        rst = 1;
        for (int i = 0; i < 3; i++) cycle();
        rst = 0;
        // R1: reset state with no acknowledge
        #1;
        chk(dreq_tx, 0, "R1 dreq_tx");
        chk(dreq_rx, 0, "R1 dreq_rx");
        chk(fifo_rdy, 0, "R1 fifo_rdy");
        chk(mac_eof, 0, "R1 mac_eof");
        chk(hi_byte_valid, 1, "R1 hi_byte_valid");
        chk(mem_addr, 0, "R1 mem_addr");
        chk(addr_valid, 0, "R1 addr_valid");
        #1;
        // R1: after reset, address during ack is {0,0,lo}
        dack_tx_n = 0; ctl_lo_addr = 8'h3C;
        #1; chk(mem_addr, 24'h00003C, "R1 cleared latches");
        cycle();

        // R2: capture middle byte on strobe, hold after it drops
        dack_tx_n = 1; ctl_adstb = 1; ctl_data = 8'h5A; cycle();
        ctl_adstb = 0; ctl_data = 8'hFF; cycle();
        dack_rx_n = 0; ctl_lo_addr = 8'h01;
        #1; chk(mem_addr, 24'h005A01, "R2 mid held");
        cycle();
        dack_rx_n = 1;

        // R3: page loads only on host page write
        host_page_data = 8'h12; cycle();
        host_page_we = 1; cycle();
        host_page_we = 0; host_page_data = 8'h99; cycle();
        dack_tx_n = 0; ctl_lo_addr = 8'h07;
        #1; chk(mem_addr, 24'h125A07, "R3 page loaded");
        cycle();

        // R7: end-of-process without last flag is ignored
        eop_n = 0;
        #1; chk(mac_eof, 0, "R7 eop without last flag");
        cycle();
        eop_n = 1;

        // R8/R9: set last+odd, eof with simultaneous rewrite keeps flags
        host_flag_we = 1; host_flag_last = 1; host_flag_odd = 1; cycle();
        eop_n = 0;
        #1; chk(mac_eof, 1, "R8 eof with last flag");
        chk(hi_byte_valid, 0, "R9 odd final word");
        cycle();
        host_flag_we = 0;
        #1; chk(mac_eof, 1, "R8 write wins over clear");
        cycle();
        #1; chk(mac_eof, 0, "R8 flag cleared after eof");
        chk(hi_byte_valid, 1, "R9 odd flag cleared");
        cycle();
        idle_inputs(); dack_tx_n = 1;
        cycle();

        // constrained random traffic
        ack_sel = 0;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(3) == 0) ack_sel = $urandom_range(2);
            dack_tx_n      = (ack_sel != 1);
            dack_rx_n      = (ack_sel != 2);
            eop_n          = !(ack_sel != 0 && $urandom_range(5) == 0);
            ctl_adstb      = ($urandom_range(4) == 0);
            ctl_data       = 8'($urandom);
            ctl_lo_addr    = 8'($urandom);
            host_page_we   = ($urandom_range(11) == 0);
            host_page_data = 8'($urandom);
            host_flag_we   = ($urandom_range(7) == 0);
            host_flag_last = 1'($urandom);
            host_flag_odd  = 1'($urandom);
            tx_space       = 1'($urandom);
            rx_avail       = 1'($urandom);
            cycle();
        end
        idle_inputs();
        finish_run();
    end
endmodule